// File: doc/BRIEF.md
# Parallel Printer Port Host Register Block

This block sits between a host register bus and a legacy printer parallel port. The host reaches eight byte offsets. Offset 0 is a data latch. Offset 1 returns a snapshot of the peripheral status lines. Offset 2 holds the control bits that drive the peripheral control lines and set the data-bus direction. The 8-bit peripheral data bus is split into an output byte, an output enable and an input byte, so that a pad ring can build the bidirectional pins.

When the enhanced mode input is high, a host access to offsets 3 to 7 starts a peripheral transfer cycle. Offset 3 starts an address cycle and offsets 4 to 7 start data cycles. The cycle lowers the matching strobe and waits for the peripheral to raise its completion line. If completion does not arrive within a parameterised ten-millisecond window, the cycle is aborted and a sticky timeout flag is set. Status input lines, the acknowledge line and the completion line all pass through a synchronizer. A rising edge on the acknowledge line raises an interrupt when interrupts are enabled.

Top module: `pport_host_regs`

## Requirements
- R1: After reset the control register reads 0xC4, every control line and both cycle strobes are high, `pd_oe` is 1, `irq` is 0 and `epp_busy` is 0.
- R2: A write to offset 2 stores bits 5..0, and reading offset 2 returns them with bits 7 and 6 forced to 1. The outputs follow on the next cycle: `stb_n` = NOT bit 0, `afd_n` = NOT bit 1, `init_n` = bit 2, `slin_n` = NOT bit 3.
- R3: While control bit 5 is 0, `pd_oe` is 1 and `pd_out` carries the last byte written to offset 0, and a read of offset 0 returns that byte. While bit 5 is 1, `pd_oe` is 0 and a read of offset 0 returns `pd_in`, sampled at the read edge.
- R4: The status byte is {NOT busy, ack_n, pe, slct, err_n, 1, 1, timeout}, with bit 7 first. It is built from the synchronized lines, so an input change shows in a read that starts at least two cycles later.
- R5: The status byte is captured at the clock edge that accepts the read. `host_rdata` keeps that value until the next read, even when the inputs change.
- R6: A write to offset 1 changes no status bit, except that a write with data bit 0 = 1 clears the timeout flag. A write with bit 0 = 0 leaves the flag set.
- R7: While `epp_mode` is 0, status bit 0 reads 1, reads of offsets 3 to 7 return 0xFF, and writes there start no cycle and leave `pd_out` unchanged.
- R8: While `epp_mode` is 1, a write to offset 3 puts the byte on `pd_out` with `pd_oe` = 1 and lowers `epp_astb_n` and `epp_wr_n` on the next cycle. A write to offsets 4 to 7 does the same with `epp_dstb_n`.
- R9: While `epp_mode` is 1, a read of offsets 4 to 7 lowers `epp_dstb_n`, keeps `epp_wr_n` high and sets `pd_oe` to 0. When the cycle completes, `host_rdata` takes the value of `pd_in`.
- R10: A cycle ends three clock edges after `epp_wait` rises (two synchronizer stages, then the sequencer). Without completion the strobe stays low for exactly CLK_PER_MS*TIMEOUT_MS cycles. It then rises and status bit 0 becomes 1.
- R11: With control bit 4 set, a rising `ack_n` raises `irq` three edges later. `irq` stays high until a status read. `irq` is forced low while bit 4 is 0, and an edge that occurs while bit 4 is 0 is not recorded.
- R12: Host accesses to offsets 3 to 7 while `epp_busy` is 1 are ignored: the strobes and `pd_out` are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| epp_mode | input | 1 | 1 = enhanced mode with transfer cycles |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_addr | input | 3 | Byte offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered read data |
| epp_busy | output | 1 | Transfer cycle in progress |
| pd_in | input | 8 | Peripheral data bus input |
| pd_out | output | 8 | Peripheral data bus output byte |
| pd_oe | output | 1 | Peripheral data bus drive enable |
| stb_n | output | 1 | Data strobe line, active low |
| afd_n | output | 1 | Auto line feed line, active low |
| init_n | output | 1 | Initialise line, active low |
| slin_n | output | 1 | Select-in line, active low |
| epp_astb_n | output | 1 | Address cycle strobe, active low |
| epp_dstb_n | output | 1 | Data cycle strobe, active low |
| epp_wr_n | output | 1 | Cycle direction, low = write |
| epp_wait | input | 1 | Peripheral completion, high = done |
| ack_n | input | 1 | Acknowledge line |
| busy | input | 1 | Peripheral busy line |
| pe | input | 1 | Paper end line |
| slct | input | 1 | Peripheral selected line |
| err_n | input | 1 | Error line, active low |
| irq | output | 1 | Interrupt request |

## Verification
A sequencer left in a busy state shows up at once as a strobe that stays low and as later offset 3 to 7 accesses being dropped. A timeout counter that is off by one moves the strobe release by a single cycle, and the bench checks the cycles just before and just after the limit. A lost interrupt-pending bit shows as `irq` falling before any status read, and a wrong edge register shows as `irq` rising after an edge that came while interrupts were disabled. Both appear within a few cycles of the acknowledge edge.

// File: rtl/pport_pkg.sv
package pport_pkg;

  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_STAT = 3'd1;
  localparam logic [2:0] OFS_CTRL = 3'd2;
  localparam logic [2:0] OFS_EADR = 3'd3;

  localparam logic [5:0] CTRL_RESET = 6'b000100;

  // Synchronized peripheral status lines
  typedef struct packed {
    logic busy;
    logic ack_n;
    logic pe;
    logic slct;
    logic err_n;
  } pins_t;

  function automatic logic [7:0] status_byte(pins_t p, logic tmo, logic epp);
    return {~p.busy, p.ack_n, p.pe, p.slct, p.err_n, 2'b11, (epp ? tmo : 1'b1)};
  endfunction

  function automatic logic [7:0] ctrl_byte(logic [5:0] c);
    return {2'b11, c};
  endfunction

  // {slin_n, init_n, afd_n, stb_n}
  function automatic logic [3:0] ctrl_lines(logic [3:0] c);
    return {~c[3], c[2], ~c[1], ~c[0]};
  endfunction

  function automatic logic is_cycle_port(logic [2:0] o);
    return o >= OFS_EADR;
  endfunction

  function automatic int unsigned tmo_cycles(int unsigned per_ms, int unsigned ms);
    return per_ms * ms;
  endfunction

endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  generate
    if (STAGES <= 1) begin : g_single
      logic [W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= din;
      end
      assign dout = q;
    end else begin : g_chain
      logic [STAGES*W-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[(STAGES-1)*W-1:0], din};
      end
      assign dout = chain[STAGES*W-1 -: W];
    end
  endgenerate

endmodule

// File: rtl/pport_irq.sv
module pport_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_s,
  input  logic ien,
  input  logic clr,
  output logic irq,
  output logic ack_rise
);

  logic ack_q;
  logic pend;

  assign ack_rise = ack_s & ~ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b1;
      pend  <= 1'b0;
    end else begin
      ack_q <= ack_s;
      if (ack_rise && ien) pend <= 1'b1;
      else if (clr)        pend <= 1'b0;
    end
  end

  assign irq = pend & ien;

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr) |=> (irq || !ien)); // R11
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(ack_rise && ien)) |=> !irq); // R11

endmodule

// File: rtl/pport_epp.sv
module pport_epp #(
  parameter int unsigned LIMIT = 1250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_wr,
  input  logic start_addr,
  input  logic wait_s,
  output logic busy,
  output logic cyc_wr,
  output logic drive,
  output logic astb_n,
  output logic dstb_n,
  output logic wr_n,
  output logic done,
  output logic tmo_evt
);

  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  typedef enum logic {ST_IDLE, ST_CYC} st_t;

  st_t          st;
  logic         cyc_addr;
  logic [CW-1:0] cnt;

  assign busy    = (st == ST_CYC);
  assign done    = busy && wait_s;
  assign tmo_evt = busy && !wait_s && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      cyc_wr   <= 1'b0;
      cyc_addr <= 1'b0;
    end else if (st == ST_IDLE) begin
      if (start) begin
        st       <= ST_CYC;
        cnt      <= '0;
        cyc_wr   <= start_wr;
        cyc_addr <= start_addr;
      end
    end else begin
      if (done || tmo_evt) st  <= ST_IDLE;
      else                 cnt <= cnt + 1'b1;
    end
  end

  assign astb_n = !(busy && cyc_addr);
  assign dstb_n = !(busy && !cyc_addr);
  assign wr_n   = !(busy && cyc_wr);
  assign drive  = busy && cyc_wr;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= LAST)); // R10
  AST_TMO_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> !busy); // R10
  AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R8

endmodule

// File: rtl/pport_host_regs.sv
module pport_host_regs
  import pport_pkg::*;
#(
  parameter int unsigned CLK_PER_MS  = 125000,
  parameter int unsigned TIMEOUT_MS  = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       epp_mode,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [2:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       epp_busy,
  input  logic [7:0] pd_in,
  output logic [7:0] pd_out,
  output logic       pd_oe,
  output logic       stb_n,
  output logic       afd_n,
  output logic       init_n,
  output logic       slin_n,
  output logic       epp_astb_n,
  output logic       epp_dstb_n,
  output logic       epp_wr_n,
  input  logic       epp_wait,
  input  logic       ack_n,
  input  logic       busy,
  input  logic       pe,
  input  logic       slct,
  input  logic       err_n,
  output logic       irq
);

  localparam int unsigned LIMIT = tmo_cycles(CLK_PER_MS, TIMEOUT_MS);
  localparam int unsigned NPIN  = 6;
  // idle levels: wait low, busy low, ack_n high, pe low, slct low, err_n high
  localparam logic [NPIN-1:0] PIN_IDLE = 6'b001001;

  // ---------------- synchronizer
  logic [NPIN-1:0] pins_s;
  pport_sync #(.W(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({epp_wait, busy, ack_n, pe, slct, err_n}),
    .dout (pins_s)
  );

  logic  wait_s;
  pins_t pins;
  assign wait_s = pins_s[5];
  assign pins   = pins_s[4:0];

  // ---------------- decode events
  logic [5:0] ctrl_q;
  logic [7:0] pd_hold;
  logic       tmo_flag;
  logic       stat_rd;
  logic       stat_wr;
  logic       tmo_clr;
  logic       cyc_start;
  logic       reg_rd;
  logic       cyc_wr, cyc_drive, cyc_done, cyc_tmo;
  logic       ack_rise;

  assign stat_rd   = host_rd && (host_addr == OFS_STAT);
  assign stat_wr   = host_wr && (host_addr == OFS_STAT);
  assign tmo_clr   = stat_wr && host_wdata[0];
  assign cyc_start = epp_mode && !epp_busy && (host_wr || host_rd) && is_cycle_port(host_addr);
  assign reg_rd    = host_rd && (!is_cycle_port(host_addr) || !epp_mode);

  // ---------------- transfer cycle sequencer
  pport_epp #(.LIMIT(LIMIT)) u_epp (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (cyc_start),
    .start_wr  (host_wr),
    .start_addr(host_addr == OFS_EADR),
    .wait_s    (wait_s),
    .busy      (epp_busy),
    .cyc_wr    (cyc_wr),
    .drive     (cyc_drive),
    .astb_n    (epp_astb_n),
    .dstb_n    (epp_dstb_n),
    .wr_n      (epp_wr_n),
    .done      (cyc_done),
    .tmo_evt   (cyc_tmo)
  );

  // ---------------- interrupt
  pport_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .ack_s   (pins.ack_n),
    .ien     (ctrl_q[4]),
    .clr     (stat_rd),
    .irq     (irq),
    .ack_rise(ack_rise)
  );

  // ---------------- registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= CTRL_RESET;
      pd_hold  <= '0;
      tmo_flag <= 1'b0;
    end else begin
      if (host_wr && host_addr == OFS_CTRL) ctrl_q <= host_wdata[5:0];
      if (host_wr && (host_addr == OFS_DATA || (cyc_start && is_cycle_port(host_addr))))
        pd_hold <= host_wdata;
      if (cyc_tmo)      tmo_flag <= 1'b1;
      else if (tmo_clr) tmo_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rdata <= '0;
    end else if (reg_rd) begin
      case (host_addr)
        OFS_DATA: host_rdata <= ctrl_q[5] ? pd_in : pd_hold;
        OFS_STAT: host_rdata <= status_byte(pins, tmo_flag, epp_mode);
        OFS_CTRL: host_rdata <= ctrl_byte(ctrl_q);
        default:  host_rdata <= 8'hFF;
      endcase
    end else if (cyc_done && !cyc_wr) begin
      host_rdata <= pd_in;
    end
  end

  // ---------------- outputs
  assign {slin_n, init_n, afd_n, stb_n} = ctrl_lines(ctrl_q[3:0]);
  assign pd_out = pd_hold;
  assign pd_oe  = epp_busy ? cyc_drive : ~ctrl_q[5];

  AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag && !tmo_clr) |=> tmo_flag); // R6
  AST_RSVD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> (host_rdata[2:1] == 2'b11)); // R4
  AST_NO_CYCLE_STD: assert property (@(posedge clk) disable iff (!rst_n)
    (!epp_mode && !epp_busy) |=> !epp_busy); // R7
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rise && ctrl_q[4] && host_wr == 1'b0) |=> irq); // R11

endmodule

// File: tb/pport_host_regs_bench.sv
module pport_host_regs_bench;

  localparam int unsigned PER_MS = 20;
  localparam int unsigned TMO_MS = 10;
  localparam int unsigned LIM    = PER_MS * TMO_MS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       epp_mode = 1'b0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [2:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       epp_busy;
  logic [7:0] pd_in = '0;
  logic [7:0] pd_out;
  logic       pd_oe, stb_n, afd_n, init_n, slin_n;
  logic       epp_astb_n, epp_dstb_n, epp_wr_n;
  logic       epp_wait = 1'b0, ack_n = 1'b1, busy = 1'b0, pe = 1'b0, slct = 1'b0, err_n = 1'b1;
  logic       irq;

  int errs = 0;
  int checks = 0;
  logic finished = 1'b0;

  always #4 clk = ~clk;

  pport_host_regs #(.CLK_PER_MS(PER_MS), .TIMEOUT_MS(TMO_MS), .SYNC_STAGES(2)) u_pport_host_regs (
    .clk(clk), .rst_n(rst_n), .epp_mode(epp_mode), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata), .epp_busy(epp_busy),
    .pd_in(pd_in), .pd_out(pd_out), .pd_oe(pd_oe), .stb_n(stb_n), .afd_n(afd_n),
    .init_n(init_n), .slin_n(slin_n), .epp_astb_n(epp_astb_n), .epp_dstb_n(epp_dstb_n),
    .epp_wr_n(epp_wr_n), .epp_wait(epp_wait), .ack_n(ack_n), .busy(busy), .pe(pe),
    .slct(slct), .err_n(err_n), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hwrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 stb_n", stb_n, 1); chk("R1 afd_n", afd_n, 1);
    chk("R1 init_n", init_n, 1); chk("R1 slin_n", slin_n, 1);
    chk("R1 pd_oe", pd_oe, 1); chk("R1 irq", irq, 0); chk("R1 busy", epp_busy, 0);
    chk("R1 strobes", {epp_astb_n, epp_dstb_n, epp_wr_n}, 3'b111);
    hread(3'd2, v); chk("R1 ctrl readback", v, 8'hC4);
  endtask

  task automatic t_control();
    logic [7:0] v;
    hwrite(3'd2, 8'h0B);
    chk("R2 lines", {slin_n, init_n, afd_n, stb_n}, 4'b0000);
    hread(3'd2, v); chk("R2 readback", v, 8'hCB);
    hwrite(3'd2, 8'h04);
    chk("R2 lines idle", {slin_n, init_n, afd_n, stb_n}, 4'b1111);
  endtask

  task automatic t_data_dir();
    logic [7:0] v;
    hwrite(3'd0, 8'hA5);
    chk("R3 pd_out", pd_out, 8'hA5); chk("R3 pd_oe out", pd_oe, 1);
    hread(3'd0, v); chk("R3 read latch", v, 8'hA5);
    hwrite(3'd2, 8'h24);
    chk("R3 pd_oe in", pd_oe, 0);
    pd_in = 8'h3C;
    hread(3'd0, v); chk("R3 read bus", v, 8'h3C);
    hwrite(3'd2, 8'h04);
  endtask

  task automatic t_status();
    logic [7:0] v;
    busy = 1'b1; ack_n = 1'b0; pe = 1'b1; slct = 1'b0; err_n = 1'b1;
    idle(3);
    hread(3'd1, v); chk("R4 layout a", v, 8'h2F);
    busy = 1'b0; ack_n = 1'b1; pe = 1'b0; slct = 1'b1; err_n = 1'b0;
    idle(3);
    chk("R5 held", host_rdata, 8'h2F);
    hread(3'd1, v); chk("R4 layout b", v, 8'hD7);
    hwrite(3'd1, 8'h00);
    hread(3'd1, v); chk("R6 write no effect", v, 8'hD7);
  endtask

  task automatic t_std_mode();
    logic [7:0] v;
    epp_mode = 1'b0;
    hwrite(3'd3, 8'h77);
    chk("R7 no strobe", {epp_astb_n, epp_dstb_n, epp_busy}, 3'b110);
    chk("R7 pd_out kept", pd_out, 8'hA5);
    hread(3'd6, v); chk("R7 read FF", v, 8'hFF);
  endtask

  task automatic t_epp_write();
    epp_mode = 1'b1;
    hwrite(3'd3, 8'h5A);
    chk("R8 addr strobe", {epp_astb_n, epp_dstb_n, epp_wr_n, epp_busy}, 4'b0101);
    chk("R8 pd drive", {pd_oe, pd_out}, {1'b1, 8'h5A});
    epp_wait = 1'b1;
    idle(2); chk("R10 held", epp_astb_n, 0);
    idle(1); chk("R10 released", {epp_astb_n, epp_busy}, 2'b10);
    epp_wait = 1'b0; idle(3);
    hwrite(3'd7, 8'h99);
    chk("R8 data strobe", {epp_astb_n, epp_dstb_n, epp_wr_n}, 3'b100);
    hwrite(3'd3, 8'h11);
    chk("R12 ignored strobe", {epp_astb_n, epp_dstb_n}, 2'b10);
    chk("R12 ignored pd", pd_out, 8'h99);
    epp_wait = 1'b1; idle(3);
    chk("R8 done", epp_busy, 0);
    epp_wait = 1'b0; idle(3);
  endtask

  task automatic t_epp_read();
    @(negedge clk);
    host_rd = 1'b1; host_addr = 3'd5;
    @(negedge clk);
    host_rd = 1'b0;
    chk("R9 read strobe", {epp_dstb_n, epp_wr_n, pd_oe}, 3'b010);
    pd_in = 8'h96; epp_wait = 1'b1;
    idle(3);
    chk("R9 data", host_rdata, 8'h96);
    chk("R9 released", epp_dstb_n, 1);
    epp_wait = 1'b0; idle(3);
  endtask

  task automatic t_timeout();
    logic [7:0] v;
    hread(3'd1, v); chk("R10 flag clear", v[0], 0);
    hwrite(3'd4, 8'hC3);
    idle(LIM - 1); chk("R10 before limit", epp_dstb_n, 0);
    idle(1); chk("R10 at limit", {epp_dstb_n, epp_busy}, 2'b10);
    hread(3'd1, v); chk("R10 flag set", v[0], 1);
    hwrite(3'd1, 8'h00);
    hread(3'd1, v); chk("R6 zero keeps", v[0], 1);
    hwrite(3'd1, 8'h01);
    hread(3'd1, v); chk("R6 one clears", v[0], 0);
    epp_mode = 1'b0;
    hread(3'd1, v); chk("R7 bit0 std", v[0], 1);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    ack_n = 1'b0; idle(3);
    hwrite(3'd2, 8'h14);
    ack_n = 1'b1;
    idle(2); chk("R11 not yet", irq, 0);
    idle(1); chk("R11 raised", irq, 1);
    idle(5); chk("R11 held", irq, 1);
    hread(3'd1, v); chk("R11 cleared by read", irq, 0);
    ack_n = 1'b0; idle(3); ack_n = 1'b1; idle(3);
    chk("R11 raised again", irq, 1);
    hwrite(3'd2, 8'h04); chk("R11 gated", irq, 0);
    hread(3'd1, v);
    ack_n = 1'b0; idle(3); ack_n = 1'b1; idle(4);
    hwrite(3'd2, 8'h14); idle(1);
    chk("R11 edge while disabled", irq, 0);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_control();
    t_data_dir();
    t_status();
    t_std_mode();
    t_epp_write();
    t_epp_read();
    t_timeout();
    t_irq();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule